// File: doc/BRIEF.md
# Four-Level Frame Sync Detector

This block sits behind a four-level symbol slicer on the receive side of a packet radio modem. Each symbol arrives as a 2-bit code with a one-cycle strobe. The block compares the last 24 symbols with a fixed frame-sync word. A small number of wrong symbols, set by a programmable threshold, is still accepted as a match. When a match is found, it raises a one-cycle sync pulse.

After a match the block stops searching. It captures the next symbol as the channel-status symbol and shows it to the host. It then raises a window flag for the 22 symbols of the station-ID field that follow. When the window closes, the search starts again. Lowering the enable aborts any frame in progress. Raising the enable again starts from an empty symbol history.

Top module: `fsync_detector`

## Requirements
- R1: After reset, `sync_pulse`, `status_vld` and `field_win` are low and `status_sym` is 00.
- R2: With a threshold of 0, sending the exact sync word raises `sync_pulse` for exactly one cycle. The pulse is seen in the cycle after the clock edge that accepts the 24th symbol, and never on any earlier symbol.
- R3: A match is declared when the number of mismatched symbol positions is at or below `err_thresh`. Two wrong symbols match with a threshold of 2 but not with a threshold of 1. Seven wrong symbols match with a threshold of 7; eight do not.
- R4: While `rx_en` is low, no symbol is taken and no sync is reported. When `rx_en` rises, the history is empty. A word split across a disabled gap therefore does not match.
- R5: The first strobe after a match is the channel-status symbol. Its code appears on `status_sym`, with a one-cycle `status_vld` pulse, in the cycle after that strobe's edge. The code is held until the next capture.
- R6: After the status symbol, `field_win` is high while exactly 22 further strobes arrive. It drops in the cycle after the 22nd of them, and the search then resumes.
- R7: No sync is reported while the status symbol or the field window is pending, even if the symbol history matches the word.
- R8: Lowering `rx_en` during a frame clears `field_win` in the next cycle. A later sync word is detected again after `rx_en` is re-raised.
- R9: Cycles without `sym_vld` do not advance the history. A sync word with idle gaps between its symbols is still detected once.
- R10: The codes are 11 = +3, 10 = +1, 00 = -1, 01 = -3. The word, first received first, is +3 +3 -3 -3 three times, then four +3, six -3 and two +3. A +1 or -1 in place of a +3 or -3 counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive search enable |
| sym_vld | input | 1 | One-cycle symbol strobe |
| sym_code | input | 2 | Received symbol code |
| err_thresh | input | 3 | Largest accepted number of mismatched symbols |
| sync_pulse | output | 1 | One-cycle pulse when the sync word is found |
| status_vld | output | 1 | One-cycle pulse when the status symbol is captured |
| status_sym | output | 2 | Last captured status symbol |
| field_win | output | 1 | High while the station-ID field symbols arrive |

## Verification
A history register that shifts on the wrong condition, or is not cleared, shows as a sync pulse on the wrong strobe or on a split word. Both are seen within the 24 symbols of one word. An error count or threshold compare that is off by one flips the result of the threshold boundary words: a detection at the limit is missed, or a word past the limit is accepted. A wrong frame state shows within one frame as a status capture on the wrong symbol, a field window that is not 22 strobes long, or a repeated sync inside the window.

// File: rtl/fsync_pkg.sv
// Shared constants for the four-level frame sync detector.
// Assumes the symbol code map 11=+3, 10=+1, 00=-1, 01=-3.
package fsync_pkg;
    localparam int SYM_W     = 2;
    localparam int SYNC_LEN  = 24;
    localparam int FIELD_LEN = 22;
    localparam int THR_W     = 3;
    // First received symbol in the most significant dibit.
    localparam logic [SYNC_LEN*SYM_W-1:0] SYNC_WORD = 48'hF5F5_F5FF_555F;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_STATUS = 2'd1,
        ST_FIELD  = 2'd2
    } frame_state_t;
endpackage

// File: rtl/fsync_history.sv
// Symbol history: keeps the last DEPTH-1 accepted symbols and joins the
// symbol on the input to form a DEPTH-symbol window, oldest in the MSBs.
// Assumes a single-cycle shift strobe; clears while disabled.
module fsync_history #(
    parameter int SYM_W = 2,
    parameter int DEPTH = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     shift,
    input  logic [SYM_W-1:0]         sym_in,
    output logic [DEPTH*SYM_W-1:0]   window
);
    localparam int HW = (DEPTH - 1) * SYM_W;

    logic [HW-1:0] hist;

    // Shift in accepted symbols; empty the history whenever disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (!en) begin
            hist <= '0;
        end else if (shift) begin
            hist <= {hist[HW-SYM_W-1:0], sym_in};
        end
    end

    // Window seen by the correlator: stored symbols plus the current one.
    assign window = {hist, sym_in};

    // The history must be empty in the cycle after a disabled cycle.
    assert_clear_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (window[DEPTH*SYM_W-1:SYM_W] == '0));
endmodule

// File: rtl/fsync_correlator.sv
// Correlator: compares each symbol of the window with the pattern and
// counts the positions that differ. Pure combinational logic.
module fsync_correlator #(
    parameter int SYM_W = 2,
    parameter int DEPTH = 24,
    parameter int CNT_W = 5
) (
    input  logic [DEPTH*SYM_W-1:0] window,
    input  logic [DEPTH*SYM_W-1:0] pattern,
    output logic [CNT_W-1:0]       err_cnt
);
    logic [DEPTH-1:0] miss;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign miss[g] = (window[g*SYM_W +: SYM_W] != pattern[g*SYM_W +: SYM_W]);
        end
    endgenerate

    // Add up the mismatch flags.
    always_comb begin
        err_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            err_cnt = err_cnt + CNT_W'(miss[i]);
        end
    end
endmodule

// File: rtl/fsync_framer.sv
// Framer: searches for a hit, then takes the status symbol, then holds
// the field window for FIELD_LEN strobes. Outputs are registered, so
// each one is seen in the cycle after the strobe edge that causes it.
module fsync_framer
    import fsync_pkg::*;
#(
    parameter int SW     = SYM_W,
    parameter int FLEN   = FIELD_LEN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_en,
    input  logic           sym_vld,
    input  logic [SW-1:0]  sym_code,
    input  logic           hit,
    output logic           sync_pulse,
    output logic           status_vld,
    output logic [SW-1:0]  status_sym,
    output logic           field_win
);
    localparam int FC_W = $clog2(FLEN);
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(FLEN - 1);

    frame_state_t    state;
    logic [FC_W-1:0] fcnt;

    // Frame sequencing: search, status capture, then field window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_SEARCH;
            fcnt       <= '0;
            sync_pulse <= 1'b0;
            status_vld <= 1'b0;
            status_sym <= '0;
        end else begin
            sync_pulse <= 1'b0;
            status_vld <= 1'b0;
            if (!rx_en) begin
                state <= ST_SEARCH;
                fcnt  <= '0;
            end else if (sym_vld) begin
                case (state)
                    ST_SEARCH: begin
                        if (hit) begin
                            sync_pulse <= 1'b1;
                            state      <= ST_STATUS;
                        end
                    end
                    ST_STATUS: begin
                        status_sym <= sym_code;
                        status_vld <= 1'b1;
                        fcnt       <= '0;
                        state      <= ST_FIELD;
                    end
                    ST_FIELD: begin
                        if (fcnt == FC_LAST) begin
                            state <= ST_SEARCH;
                        end else begin
                            fcnt <= fcnt + 1'b1;
                        end
                    end
                    default: state <= ST_SEARCH;
                endcase
            end
        end
    end

    // The window flag follows the field state.
    assign field_win = (state == ST_FIELD);

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);
    assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!sync_pulse && !field_win && !status_vld));
    assert_window_opens_on_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(field_win) |-> status_vld);
    assert_status_opens_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_vld |-> field_win);
    assert_no_sync_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        field_win |-> !sync_pulse);
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (field_win && !rx_en) |=> !field_win);
endmodule

// File: rtl/fsync_detector.sv
// Four-level frame sync detector top: history, correlator and framer.
// A hit is an error count at or below the programmed threshold on a
// strobed symbol. Assumes one symbol per sym_vld pulse.
module fsync_detector
    import fsync_pkg::*;
#(
    parameter int                            SW      = SYM_W,
    parameter int                            SLEN    = SYNC_LEN,
    parameter int                            FLEN    = FIELD_LEN,
    parameter int                            TW      = THR_W,
    parameter logic [SYNC_LEN*SYM_W-1:0]     PATTERN = SYNC_WORD
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_en,
    input  logic           sym_vld,
    input  logic [SW-1:0]  sym_code,
    input  logic [TW-1:0]  err_thresh,
    output logic           sync_pulse,
    output logic           status_vld,
    output logic [SW-1:0]  status_sym,
    output logic           field_win
);
    localparam int CNT_W = $clog2(SLEN + 1);

    logic [SLEN*SW-1:0] window;
    logic [CNT_W-1:0]   err_cnt;
    logic               hit;

    fsync_history #(.SYM_W(SW), .DEPTH(SLEN)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rx_en),
        .shift  (sym_vld),
        .sym_in (sym_code),
        .window (window)
    );

    fsync_correlator #(.SYM_W(SW), .DEPTH(SLEN), .CNT_W(CNT_W)) u_corr (
        .window  (window),
        .pattern (PATTERN[SLEN*SW-1:0]),
        .err_cnt (err_cnt)
    );

    // Threshold test on the mismatch count.
    assign hit = (err_cnt <= CNT_W'(err_thresh));

    fsync_framer #(.SW(SW), .FLEN(FLEN)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .sym_vld    (sym_vld),
        .sym_code   (sym_code),
        .hit        (hit),
        .sync_pulse (sync_pulse),
        .status_vld (status_vld),
        .status_sym (status_sym),
        .field_win  (field_win)
    );

    assert_sync_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> ($past(rx_en) && $past(sym_vld)));
    assert_sync_within_thresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> ($past(err_cnt) <= CNT_W'($past(err_thresh))));
endmodule

// File: tb/tb_fsync_detector.sv
// Directed bench for the frame sync detector. One task per scenario.
module tb_fsync_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       sym_vld = 1'b0;
    logic [1:0] sym_code = 2'b00;
    logic [2:0] err_thresh = 3'd0;
    logic       sync_pulse, status_vld, field_win;
    logic [1:0] status_sym;

    // Sync word from R10, first received symbol in the top dibit.
    localparam logic [47:0] WORD = 48'hF5F5_F5FF_555F;

    int n_chk = 0;
    int n_fail = 0;
    int n_sync = 0;
    int n_win = 0;
    logic got_sync, got_stat, win_at_strobe;

    always #4 clk = ~clk;

    fsync_detector dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sym_vld(sym_vld),
        .sym_code(sym_code), .err_thresh(err_thresh),
        .sync_pulse(sync_pulse), .status_vld(status_vld),
        .status_sym(status_sym), .field_win(field_win)
    );

    function automatic logic [1:0] pat(input int i);
        return WORD[2*(23-i) +: 2];
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_sym(input logic [1:0] c, input int gap);
        @(negedge clk);
        win_at_strobe = field_win;
        sym_code = c;
        sym_vld = 1'b1;
        @(negedge clk);
        sym_vld = 1'b0;
        got_sync = sync_pulse;
        got_stat = status_vld;
        if (got_sync) n_sync++;
        if (win_at_strobe) n_win++;
        repeat (gap) @(negedge clk);
    endtask

    // Send symbols first..last of the word; flip[i] swaps +3 and -3.
    task automatic send_word(input int first, input int last, input logic [23:0] flip, input int gap);
        for (int i = first; i <= last; i++) begin
            logic [1:0] c;
            c = pat(i);
            if (flip[i]) c = (c == 2'b11) ? 2'b01 : 2'b11;
            send_sym(c, gap);
        end
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        rx_en = v;
        @(negedge clk);
    endtask

    task automatic restart(input logic [2:0] thr);
        set_en(1'b0);
        err_thresh = thr;
        set_en(1'b1);
        n_sync = 0;
    endtask

    task automatic t_reset;
        check(!sync_pulse && !status_vld && !field_win, "R1 outputs", {sync_pulse, status_vld, field_win}, 0);
        check(status_sym == 2'b00, "R1 status_sym", status_sym, 0);
    endtask

    task automatic t_exact_frame;
        restart(3'd0);
        send_word(0, 22, 24'h0, 0);
        check(n_sync == 0, "R2 early pulse", n_sync, 0);
        send_word(23, 23, 24'h0, 0);
        check(got_sync == 1'b1, "R2 R10 pulse on 24th", got_sync, 1);
        @(negedge clk);
        check(sync_pulse == 1'b0, "R2 single cycle", sync_pulse, 0);
        send_sym(2'b11, 0);
        check(got_stat == 1'b1 && status_sym == 2'b11, "R5 status capture", status_sym, 3);
        n_win = 0; n_sync = 0;
        // Field repeats the word tail so the history matches at its end.
        send_word(2, 23, 24'h0, 0);
        check(n_win == 22, "R6 window length", n_win, 22);
        check(n_sync == 0, "R7 no sync in window", n_sync, 0);
        check(field_win == 1'b0, "R6 window closed", field_win, 0);
        n_sync = 0;
        send_word(0, 23, 24'h0, 0);
        check(n_sync == 1 && got_sync, "R6 search resumes", n_sync, 1);
        send_sym(2'b10, 0);
        check(got_stat && status_sym == 2'b10, "R5 status +1", status_sym, 2);
        send_sym(2'b00, 2);
        check(status_sym == 2'b10, "R5 status held", status_sym, 2);
    endtask

    task automatic t_abort;
        restart(3'd0);
        send_word(0, 23, 24'h0, 0);
        send_sym(2'b01, 0);
        for (int i = 0; i < 5; i++) send_sym(2'b11, 0);
        check(field_win == 1'b1, "R8 window open", field_win, 1);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        check(field_win == 1'b0, "R8 abort clears window", field_win, 0);
        set_en(1'b1);
        n_sync = 0;
        send_word(0, 23, 24'h0, 0);
        check(n_sync == 1, "R8 detect after abort", n_sync, 1);
    endtask

    task automatic t_threshold;
        restart(3'd2);
        send_word(0, 23, 24'h020008, 0);
        check(n_sync == 1, "R3 two errors thr 2", n_sync, 1);
        restart(3'd1);
        send_word(0, 23, 24'h020008, 0);
        check(n_sync == 0, "R3 two errors thr 1", n_sync, 0);
        restart(3'd7);
        send_word(0, 23, 24'h49_2481, 0);
        check(n_sync == 1, "R3 seven errors thr 7", n_sync, 1);
        restart(3'd7);
        send_word(0, 23, 24'hC9_2481, 0);
        check(n_sync == 0, "R3 eight errors thr 7", n_sync, 0);
    endtask

    task automatic t_codes;
        restart(3'd0);
        send_word(0, 4, 24'h0, 0);
        send_sym(2'b10, 0);
        send_word(6, 23, 24'h0, 0);
        check(n_sync == 0, "R10 +1 for +3", n_sync, 0);
        restart(3'd0);
        send_word(0, 1, 24'h0, 0);
        send_sym(2'b00, 0);
        send_word(3, 23, 24'h0, 0);
        check(n_sync == 0, "R10 -1 for -3", n_sync, 0);
    endtask

    task automatic t_disable;
        restart(3'd0);
        send_word(0, 11, 24'h0, 0);
        set_en(1'b0);
        send_word(12, 23, 24'h0, 0);
        check(n_sync == 0, "R4 no sync while off", n_sync, 0);
        set_en(1'b1);
        send_word(12, 23, 24'h0, 0);
        check(n_sync == 0, "R4 history cleared", n_sync, 0);
        set_en(1'b0);
        send_word(0, 23, 24'h0, 0);
        check(n_sync == 0 && !field_win, "R4 full word while off", n_sync, 0);
    endtask

    task automatic t_gaps;
        restart(3'd0);
        send_word(0, 23, 24'h0, 3);
        check(n_sync == 1, "R9 gapped word", n_sync, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact_frame();
        t_abort();
        t_threshold();
        t_codes();
        t_disable();
        t_gaps();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule